// File: doc/BRIEF.md
# Buffered Three-Output PWM Submodule

This block generates three pulse-width-modulated outputs (X, A and B) from one shared 16-bit up-counter. A power-of-two prescaler sets how many clocks pass per count. The counter runs from zero up to a programmable period value and then returns to zero. Each output has one compare value that drives it high and one that drives it low. Output X is always driven low at the period value, so only its rising edge can be moved.

All period, compare and prescale settings pass through shadow registers. Software disarms the load flag, writes any of the shadow values and then arms the flag again. The armed set moves into the active set as one unit at the next period wrap, or on the next clock while the counter is stopped. The flag then clears itself. A partly written update therefore never reaches the outputs.

A simple write port configures the block. A run input starts and stops the counter, and one enable bit per output gates each pin.

Top module: `pwm_submod`

## Requirements
- R1: After reset all three pins are low, the load flag reads 0, and every shadow and active setting is zero.
- R2: While running, the counter advances once every 2^p clocks, where p is the 3-bit prescale setting. It counts 0, 1, ..., period and then returns to 0, so one PWM period lasts (period+1)·2^p clocks.
- R3: The A level becomes 1 on the clock edge that ends a cycle in which the count equals the A-on value. It becomes 0 on the edge that ends a cycle in which the count equals the A-off value.
- R4: The B level follows the same rule as R3, using the B-on and B-off values.
- R5: The X level becomes 1 on the edge that ends a cycle in which the count equals the X-on value. It becomes 0 on the edge that ends a cycle in which the count equals the period value.
- R6: When the on match and the off match of an output fall in the same cycle, the off match wins and the level goes to 0.
- R7: Write addresses are: 0 period, 1 X-on, 2 A-on, 3 A-off, 4 B-on, 5 B-off, 6 prescale (data bits 2:0). Writes to these addresses change only the shadow set. The shadow set is copied into the active set only when the load flag is 1, at the edge where the count wraps from period to 0, or at any edge while run is low.
- R8: A write to address 7 sets the load flag to data bit 0. The flag clears itself at the edge that performs the copy, unless an address-7 write lands on that same edge; in that case the write wins. The flag is visible on `load_armed`.
- R9: An A-off or B-off value greater than the period never matches. Once that output has been set it stays high, giving 100 percent duty.
- R10: Bit 0 of `out_en` gates X, bit 1 gates A and bit 2 gates B. A disabled pin is low while its internal level keeps following R3 to R5, and the pin shows that level again as soon as it is re-enabled.
- R11: While run is low, the counter and the prescaler are held at 0 and all three levels are cleared, so every pin is low. After run rises, counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register write |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 16 | Write data |
| run | input | 1 | Counter run enable |
| out_en | input | 3 | Per-output enables: bit 0 X, bit 1 A, bit 2 B |
| pwm_x | output | 1 | Output X |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| load_armed | output | 1 | Current state of the load flag |

## Verification
The assertions take for granted that the active period is changed only by the copy step. They also assume that the prescale value is never taken from bits outside its 3-bit field. Given that, the counter bound and the prescaler bound hold by induction from reset. The stimulus keeps every write on a legal address and drives inputs half a cycle away from the sampling edge. It uses small periods and prescale values of 0 to 2, so that many wraps, copies and same-edge write collisions occur within a short run. Compare values are drawn from a range slightly above the period, so that matches which never happen (R9) and same-cycle on/off matches (R6) both occur during the random phase.

// File: rtl/pwm_submod_pkg.sv
package pwm_submod_pkg;
   localparam int unsigned ADDR_W   = 4;
   localparam int unsigned NUM_CMP  = 6;
   localparam int unsigned NUM_OUT  = 3;
   // write-port addresses; indices 0..5 also index the compare arrays
   localparam int unsigned IDX_PERIOD = 0;
   localparam int unsigned IDX_X_ON   = 1;
   localparam int unsigned IDX_A_ON   = 2;
   localparam int unsigned IDX_A_OFF  = 3;
   localparam int unsigned IDX_B_ON   = 4;
   localparam int unsigned IDX_B_OFF  = 5;
   localparam int unsigned IDX_PRSC   = 6;
   localparam int unsigned IDX_LOAD   = 7;
   // output slots
   localparam int unsigned OUT_X = 0;
   localparam int unsigned OUT_A = 1;
   localparam int unsigned OUT_B = 2;

   function automatic int unsigned on_index(input int unsigned o);
      return (o == OUT_X) ? IDX_X_ON : (o == OUT_A) ? IDX_A_ON : IDX_B_ON;
   endfunction

   function automatic int unsigned off_index(input int unsigned o);
      return (o == OUT_X) ? IDX_PERIOD : (o == OUT_A) ? IDX_A_OFF : IDX_B_OFF;
   endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned PRSC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRSC_W-1:0] prsc,
   output logic              tick
);
   localparam int unsigned DIV_W = (1 << PRSC_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < DIV_W; i++) begin
         mask[i] = (i < int'(prsc));
      end
   end

   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R2
   div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= mask);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap = run && tick && (cnt_q == period);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= period);

   // R11
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_edge_out.sv
module pwm_edge_out #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] on_val,
   input  logic [CNT_W-1:0] off_val,
   output logic             level
);
   logic level_q;

   assign level = level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
      end else if (!run) begin
         level_q <= 1'b0;
      end else if (cnt == off_val) begin
         level_q <= 1'b0;
      end else if (cnt == on_val) begin
         level_q <= 1'b1;
      end
   end

   // R6
   off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cnt == off_val)) |=> !level_q);

   // R11
   stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !level_q);
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
   import pwm_submod_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PRSC_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [CNT_W-1:0]                wr_data,
   input  logic                            run,
   input  logic                            wrap,
   output logic [NUM_CMP-1:0][CNT_W-1:0]   act_cmp,
   output logic [PRSC_W-1:0]               act_prsc,
   output logic                            load_armed
);
   logic [NUM_CMP-1:0][CNT_W-1:0] shd_cmp;
   logic [PRSC_W-1:0]             shd_prsc;
   logic                          armed_q;
   logic                          xfer;
   logic                          load_wr;

   assign load_wr    = wr_en && (wr_addr == ADDR_W'(IDX_LOAD));
   assign xfer       = armed_q && (wrap || !run);
   assign load_armed = armed_q;

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_cmp[g] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
            shd_cmp[g] <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_cmp[g] <= '0;
         end else if (xfer) begin
            act_cmp[g] <= shd_cmp[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_prsc <= '0;
         act_prsc <= '0;
      end else begin
         if (wr_en && (wr_addr == ADDR_W'(IDX_PRSC))) begin
            shd_prsc <= wr_data[PRSC_W-1:0];
         end
         if (xfer) begin
            act_prsc <= shd_prsc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (load_wr) begin
         armed_q <= wr_data[0];
      end else if (xfer) begin
         armed_q <= 1'b0;
      end
   end

   // R7
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(act_cmp) && $stable(act_prsc)));

   // R7
   unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> $stable(act_cmp));

   // R8
   armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wrap && !load_wr) |=> !armed_q);
endmodule

// File: rtl/pwm_submod.sv
module pwm_submod
   import pwm_submod_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PRSC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              run,
   input  logic [NUM_OUT-1:0] out_en,
   output logic              pwm_x,
   output logic              pwm_a,
   output logic              pwm_b,
   output logic              load_armed
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwm_submod: CNT_W must lie in 2..32");
   end
   if (PRSC_W < 1 || PRSC_W > 4) begin : g_bad_prsc_w
      $error("pwm_submod: PRSC_W must lie in 1..4");
   end
   if (CNT_W < PRSC_W) begin : g_bad_data_w
      $error("pwm_submod: write data narrower than prescale field");
   end

   logic [NUM_CMP-1:0][CNT_W-1:0] act_cmp;
   logic [PRSC_W-1:0]             act_prsc;
   logic [CNT_W-1:0]              cnt;
   logic                          tick;
   logic                          wrap;
   logic [NUM_OUT-1:0]            level;
   logic [NUM_OUT-1:0]            pin;

   pwm_shadow #(.CNT_W(CNT_W), .PRSC_W(PRSC_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .run        (run),
      .wrap       (wrap),
      .act_cmp    (act_cmp),
      .act_prsc   (act_prsc),
      .load_armed (load_armed)
   );

   pwm_prescaler #(.PRSC_W(PRSC_W)) u_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .prsc  (act_prsc),
      .tick  (tick)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .period (act_cmp[IDX_PERIOD]),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      localparam int unsigned ON_I  = on_index(g);
      localparam int unsigned OFF_I = off_index(g);

      pwm_edge_out #(.CNT_W(CNT_W)) u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run),
         .cnt     (cnt),
         .on_val  (act_cmp[ON_I]),
         .off_val (act_cmp[OFF_I]),
         .level   (level[g])
      );

      assign pin[g] = level[g] & out_en[g];
   end

   assign pwm_x = pin[OUT_X];
   assign pwm_a = pin[OUT_A];
   assign pwm_b = pin[OUT_B];

   // R5
   x_low_after_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !level[OUT_X]);
endmodule

// File: tb/test_pwm_submod.sv
module test_pwm_submod;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        run = 1'b0;
   logic [2:0]  out_en = '0;
   logic        pwm_x, pwm_a, pwm_b, load_armed;

   int n_cmp = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_submod i_pwm_submod (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .run(run), .out_en(out_en),
      .pwm_x(pwm_x), .pwm_a(pwm_a), .pwm_b(pwm_b), .load_armed(load_armed)
   );

   // ---------------- reference model built from the requirements ----------------
   logic [15:0] m_shd [7];
   logic [15:0] m_act [7];
   logic        m_armed;
   int          m_div;
   logic [15:0] m_cnt;
   logic [2:0]  m_lvl;

   function automatic int on_i(input int o);
      return (o == 0) ? 1 : (o == 1) ? 2 : 4;
   endfunction
   function automatic int off_i(input int o);
      return (o == 0) ? 0 : (o == 1) ? 3 : 5;
   endfunction
   function automatic int exp_gap(input int per, input int p);
      return (per + 1) << p;
   endfunction
   // high clocks per period for an output with on/off compares (R3..R6, R9)
   function automatic int exp_high(input int on, input int off, input int per, input int p);
      if (on > per || on == off) return 0;
      if (off > per) return (per + 1) << p;
      if (off > on) return (off - on) << p;
      return ((per + 1) - (on - off)) << p;
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      int  mask;
      bit  tk, wp, xf;
      if (!rst_n) begin
         m_armed <= 1'b0; m_div <= 0; m_cnt <= '0; m_lvl <= '0;
         for (int k = 0; k < 7; k++) begin
            m_shd[k] <= '0; m_act[k] <= '0;
         end
      end else begin
         mask = (1 << m_act[6][2:0]) - 1;
         tk = run && ((m_div & mask) == mask);
         wp = tk && (m_cnt == m_act[0]);
         xf = m_armed && (wp || !run);
         for (int o = 0; o < 3; o++) begin
            if (!run) m_lvl[o] <= 1'b0;
            else if (m_cnt == m_act[off_i(o)]) m_lvl[o] <= 1'b0;
            else if (m_cnt == m_act[on_i(o)]) m_lvl[o] <= 1'b1;
         end
         m_div <= (!run || tk) ? 0 : m_div + 1;
         if (!run) m_cnt <= '0;
         else if (tk) m_cnt <= wp ? 16'd0 : m_cnt + 16'd1;
         if (xf) for (int k = 0; k < 7; k++) m_act[k] <= m_shd[k];
         if (wr_en && wr_addr == 4'd7) m_armed <= wr_data[0];
         else if (xf) m_armed <= 1'b0;
         if (wr_en && wr_addr < 4'd7)
            m_shd[wr_addr] <= (wr_addr == 4'd6) ? {13'd0, wr_data[2:0]} : wr_data;
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_on) begin
         check("R5 pwm_x vs model", int'(pwm_x), int'(m_lvl[0] & out_en[0]));
         check("R3 pwm_a vs model", int'(pwm_a), int'(m_lvl[1] & out_en[1]));
         check("R4 pwm_b vs model", int'(pwm_b), int'(m_lvl[2] & out_en[2]));
         check("R8 load_armed vs model", int'(load_armed), int'(m_armed));
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
   endtask

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      step();
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int per, input int xon, input int aon, input int aoff,
                      input int bon, input int boff, input int p);
      wr(7, 0);
      wr(0, per); wr(1, xon); wr(2, aon); wr(3, aoff);
      wr(4, bon); wr(5, boff); wr(6, p);
      wr(7, 1);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic rise_gap(output int gap);
      logic prev;
      int   guard;
      gap = -1;
      prev = pwm_x; guard = 0;
      while (guard < 300) begin
         step(); guard++;
         if (!prev && pwm_x) break;
         prev = pwm_x;
      end
      if (guard >= 300) return;
      prev = pwm_x; gap = 0;
      while (gap < 300) begin
         step(); gap++;
         if (!prev && pwm_x) return;
         prev = pwm_x;
      end
   endtask

   task automatic count_high(input int n, input int which, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         c += (which == 0) ? int'(pwm_x) : (which == 1) ? int'(pwm_a) : int'(pwm_b);
         step();
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin : main
      int g, c, r;
      r = $urandom(32'd2024);
      steps(4);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 pwm_x after reset", int'(pwm_x), 0);
      check("R1 pwm_a after reset", int'(pwm_a), 0);
      check("R1 pwm_b after reset", int'(pwm_b), 0);
      check("R1 load_armed after reset", int'(load_armed), 0);
      chk_on = 1'b1;

      // stopped: armed copy happens on the next edge (R7, R8)
      cfg(9, 4, 0, 5, 3, 7, 0);
      check("R8 flag set by write", int'(load_armed), 1);
      step();
      check("R7 stopped copy clears flag", int'(load_armed), 0);

      out_en = 3'b111;
      run = 1'b1;
      steps(25);
      count_high(10, 1, c); check("R3 A high clocks per period", c, exp_high(0, 5, 9, 0));
      count_high(10, 2, c); check("R4 B high clocks per period", c, exp_high(3, 7, 9, 0));
      count_high(10, 0, c); check("R5 X high clocks per period", c, exp_high(4, 9, 9, 0));
      rise_gap(g); check("R2 period, prescale 0", g, exp_gap(9, 0));

      // unarmed writes must not take effect (R7)
      wr(7, 0);
      wr(0, 5); wr(6, 1);
      steps(30);
      rise_gap(g); check("R7 unarmed writes ignored", g, exp_gap(9, 0));
      wr(7, 1);
      steps(30);
      check("R8 flag cleared after wrap copy", int'(load_armed), 0);
      rise_gap(g); check("R2 period, prescale 1", g, exp_gap(5, 1));

      // coincident on/off: off wins (R6)
      cfg(7, 2, 3, 3, 1, 4, 0);
      steps(30);
      count_high(16, 1, c); check("R6 same-cycle on/off keeps A low", c, 0);

      // off beyond period: constant high (R9)
      cfg(7, 2, 2, 8, 1, 9, 0);
      steps(30);
      count_high(16, 1, c); check("R9 A 100 percent duty", c, 16);
      count_high(16, 2, c); check("R9 B 100 percent duty", c, 16);

      // per-output enable (R10)
      cfg(7, 2, 1, 5, 2, 6, 0);
      steps(30);
      out_en = 3'b101;
      count_high(16, 1, c); check("R10 disabled A stays low", c, 0);
      count_high(16, 0, c); check("R10 enabled X still toggles", c, 2 * exp_high(2, 7, 7, 0));
      out_en = 3'b111;
      count_high(16, 1, c); check("R10 A back after enable", c, 2 * exp_high(1, 5, 7, 0));

      // stop (R11)
      run = 1'b0;
      step();
      check("R11 X low while stopped", int'(pwm_x), 0);
      check("R11 A low while stopped", int'(pwm_a), 0);
      check("R11 B low while stopped", int'(pwm_b), 0);
      run = 1'b1;
      steps(10);

      // constrained random phase, checked cycle by cycle against the model
      for (int rnd = 0; rnd < 30; rnd++) begin
         int per;
         per = int'($urandom % 16);
         if ($urandom % 4 == 0) wr(7, 0);
         wr(0, per);
         wr(1, int'($urandom % (per + 3)));
         wr(2, int'($urandom % (per + 3)));
         wr(3, int'($urandom % (per + 3)));
         wr(4, int'($urandom % (per + 3)));
         wr(5, int'($urandom % (per + 3)));
         wr(6, int'($urandom % 3));
         out_en = 3'($urandom);
         if ($urandom % 3 != 0) wr(7, 1);
         for (int i = 0; i < 50; i++) begin
            if ($urandom % 25 == 0) run = ~run;
            if ($urandom % 20 == 0) wr(7, int'($urandom % 2));
            else step();
         end
         run = 1'b1;
      end

      chk_on = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule